// File: doc/BRIEF.md
# Priority-Selected Register Load

This block holds one destination register that can take its next value from any of three source buses. Three condition inputs decide whether a load happens and which source wins. The conditions form a fixed priority chain. The first condition wins whenever it is true. The second counts only when the first is false. The third counts only when both earlier ones are false.

A small combinational control unit turns the conditions into a two-bit multiplexer select and a load enable. The destination register captures the selected bus, all bits at once, on the next rising clock edge. The select and the load enable are brought out as ports so that neighbouring logic and checkers can watch them. When no condition is active, the register keeps its value.

Top module: `prio_src_load`

## Requirements
- R1: When `cond_a` is high, `dst_q` equals `src_a` after the next rising edge, whatever `cond_b` and `cond_c` are.
- R2: When `cond_a` is low and `cond_b` is high, `dst_q` equals `src_b` after the next rising edge, whatever `cond_c` is.
- R3: When `cond_a` and `cond_b` are low and `cond_c` is high, `dst_q` equals `src_c` after the next rising edge.
- R4: `sel` is combinational in the conditions. It reads 2'b00 when `cond_a` wins, 2'b01 when `cond_b` wins and 2'b10 when `cond_c` wins. It reads 2'b00 when no condition is active. It never takes 2'b11.
- R5: `load_en` is high exactly when at least one of `cond_a`, `cond_b` or `cond_c` is high, in the same cycle.
- R6: When all three conditions are low, `dst_q` keeps its previous value across the clock edge.
- R7: When `rst_n` is low at a rising edge, `dst_q` becomes zero after that edge. This holds even while conditions are active.
- R8: All WIDTH bits of the chosen source are loaded on the same edge. This includes all-zero, all-one and alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_a | input | 1 | Highest-priority load condition |
| cond_b | input | 1 | Middle-priority load condition |
| cond_c | input | 1 | Lowest-priority load condition |
| src_a | input | WIDTH | Source bus chosen by `cond_a` |
| src_b | input | WIDTH | Source bus chosen by `cond_b` |
| src_c | input | WIDTH | Source bus chosen by `cond_c` |
| dst_q | output | WIDTH | Destination register contents |
| sel | output | 2 | Multiplexer select code |
| load_en | output | 1 | Load enable for the destination |

## Verification
A fault in the priority decode shows up on `sel` and `load_en` in the same cycle the conditions are applied. It then shows up in `dst_q` one edge later as a value taken from the wrong bus. A fault in the hold path shows up as a change in `dst_q` after an edge with every condition low. A stuck or crossed bit shows up as soon as a source pattern sets that bit differently from its neighbours. The bench therefore sweeps all eight condition combinations across several source patterns and checks the combinational outputs and the register on every step.

// File: rtl/prio_src_load_pkg.sv
// Package: shared types for the priority-selected register load.
// Assumes three sources; select code 2'b11 is reserved and unused.
package prio_src_load_pkg;

    typedef enum logic [1:0] {
        SEL_SRC_A = 2'b00,
        SEL_SRC_B = 2'b01,
        SEL_SRC_C = 2'b10,
        SEL_NONE  = 2'b11
    } src_sel_e;

endpackage

// File: rtl/prio_src_ctrl.sv
// Module: priority control unit.
// Turns three condition inputs into a source select and a load enable.
// Assumes the conditions are stable around the clock edge; purely combinational.
module prio_src_ctrl
    import prio_src_load_pkg::*;
(
    input  logic     cond_a,
    input  logic     cond_b,
    input  logic     cond_c,
    output src_sel_e sel,
    output logic     load
);

    // Priority chain: the first condition wins, then the second, then the third.
    always_comb begin
        sel  = SEL_SRC_A;
        load = 1'b0;
        if (cond_a) begin
            sel  = SEL_SRC_A;
            load = 1'b1;
        end else if (cond_b) begin
            sel  = SEL_SRC_B;
            load = 1'b1;
        end else if (cond_c) begin
            sel  = SEL_SRC_C;
            load = 1'b1;
        end
    end

endmodule

// File: rtl/prio_src_mux.sv
// Module: three-input source multiplexer, built bit by bit.
// Assumes the select comes from prio_src_ctrl; the reserved code yields zero.
module prio_src_mux
    import prio_src_load_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  src_sel_e           sel,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    input  logic [WIDTH-1:0]   in_c,
    output logic [WIDTH-1:0]   out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Per-bit select of one of three inputs; reserved code forces zero.
        always_comb begin
            case (sel)
                SEL_SRC_A: out[i] = in_a[i];
                SEL_SRC_B: out[i] = in_b[i];
                SEL_SRC_C: out[i] = in_c[i];
                default:   out[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/prio_load_reg.sv
// Module: parallel-load register with synchronous active-low clear.
// Assumes load and data settle before the rising edge.
module prio_load_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Clears on reset, captures all bits on load, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/prio_src_load.sv
// Module: top of the priority-selected register load.
// Wires the control unit, the multiplexer and the destination register.
// Assumes synchronous active-low reset and a single clock domain.
module prio_src_load
    import prio_src_load_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond_a,
    input  logic             cond_b,
    input  logic             cond_c,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0] src_c,
    output logic [WIDTH-1:0] dst_q,
    output logic [1:0]       sel,
    output logic             load_en
);

    src_sel_e         sel_w;
    logic             load_w;
    logic [WIDTH-1:0] mux_w;

    prio_src_ctrl u_ctrl (
        .cond_a (cond_a),
        .cond_b (cond_b),
        .cond_c (cond_c),
        .sel    (sel_w),
        .load   (load_w)
    );

    prio_src_mux #(.WIDTH(WIDTH)) u_mux (
        .sel  (sel_w),
        .in_a (src_a),
        .in_b (src_b),
        .in_c (src_c),
        .out  (mux_w)
    );

    prio_load_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .d     (mux_w),
        .q     (dst_q)
    );

    assign sel     = sel_w;
    assign load_en = load_w;

    // R1
    a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_a |=> dst_q == $past(src_a));

    // R2
    b_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_a && cond_b) |=> dst_q == $past(src_b));

    // R3
    c_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_a && !cond_b && cond_c) |=> dst_q == $past(src_c));

    // R4
    no_reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b11);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_a && !cond_b && !cond_c) |=> $stable(dst_q));

endmodule

// File: tb/prio_src_load_tb.sv
module prio_src_load_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cond_a, cond_b, cond_c;
    logic [W-1:0] src_a, src_b, src_c;
    logic [W-1:0] dst_q;
    logic [1:0]   sel;
    logic         load_en;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] model;

    always #4 clk = ~clk;

    prio_src_load #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cond_a(cond_a), .cond_b(cond_b), .cond_c(cond_c),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .dst_q(dst_q), .sel(sel), .load_en(load_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cond_a = 1'b0; cond_b = 1'b0; cond_c = 1'b0;
        src_a = 8'h11; src_b = 8'h22; src_c = 8'h33;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 reset clears", dst_q, 0);
        model = '0;
        rst_n = 1'b1;

        // Sweep source patterns and every condition combination.
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic [W-1:0] ea;
                logic [1:0]   es;
                logic         el;
                case (p)
                    0: begin src_a = 8'hFF; src_b = 8'h00; src_c = 8'hAA; end
                    1: begin src_a = 8'h55; src_b = 8'hFF; src_c = 8'h00; end
                    2: begin src_a = 8'h00; src_b = 8'hAA; src_c = 8'hFF; end
                    default: begin
                        src_a = W'(p * 37 + c);
                        src_b = W'(p * 53 + c * 3 + 1);
                        src_c = W'(p * 71 + c * 5 + 2);
                    end
                endcase
                cond_a = c[2]; cond_b = c[1]; cond_c = c[0];
                el = cond_a | cond_b | cond_c;
                es = cond_a ? 2'd0 : (cond_b ? 2'd1 : (cond_c ? 2'd2 : 2'd0));
                ea = cond_a ? src_a : (cond_b ? src_b : (cond_c ? src_c : model));
                #1;
                check("R4 select code", sel, es);
                check("R5 load enable", load_en, el);
                @(posedge clk);
                @(negedge clk);
                model = ea;
                if (cond_a)      check("R1 source a taken", dst_q, ea);
                else if (cond_b) check("R2 source b taken", dst_q, ea);
                else if (cond_c) check("R3 source c taken", dst_q, ea);
                else             check("R6 hold when idle", dst_q, ea);
                if (p < 3 && el) check("R8 parallel bit pattern", dst_q, ea);
            end
        end

        // Reset overrides an active condition.
        cond_a = 1'b1; cond_b = 1'b1; cond_c = 1'b1; src_a = 8'hC3;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 reset over active condition", dst_q, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 load after reset release", dst_q, 8'hC3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule